// File: doc/BRIEF.md
# Supply and Regulator Reset Sequencer

This block turns four digitized voltage comparator flags into one shared active-low system reset. The four flags are supply undervoltage, supply overvoltage, regulator-output undervoltage and regulator-output overvoltage. The reset drives two identical reset outputs. All timing comes from a one-cycle `tick` strobe, nominally 1 kHz, that qualifies a fast system clock.

Short supply-overvoltage spikes, such as inductive kickback when a relay opens, are filtered out. A saturating up/down persistence counter is used, and it filters removal of the overvoltage the same way. An accepted supply overvoltage has three effects: it turns the regulator enable off, it raises an inhibit for the relay and lamp power stages, and it holds reset.

Once every fault clears, reset is held for a fixed number of ticks before it is released. Supply undervoltage counts as a fault only until the first reset release after power-on. A regulator overvoltage latches an error flag that only a power-on reset clears.

Top module: `supply_reset_seq`

## Requirements
- R1: While `reg_uv` or `reg_ov` is high, or while `sup_uv` is high before the first release, or while supply overvoltage is accepted, reset (`rst_a_n`) is low from the following clock edge, and the release count returns to zero.
- R2: `rst_a_n` and `rst_b_n` carry the same value in every cycle.
- R3: The supply-overvoltage filter is a 2-bit saturating counter. On each tick it steps up while `sup_ov` is high and down while it is low. Overvoltage is accepted on the tick where the counter reaches 3, so a burst of one or two high ticks is ignored.
- R4: Accepted overvoltage is withdrawn only on the tick where the counter reaches 0, which is three low ticks after saturation.
- R5: Reset is released high on the 52nd consecutive fault-free tick, and not on the 51st.
- R6: After the first reset release, `sup_uv` has no effect on reset.
- R7: While supply overvoltage is accepted, `pwr_inhibit` is 1 and `reg_en` is 0. Otherwise `pwr_inhibit` is 0 and `reg_en` is 1.
- R8: `reg_ov` high at a clock edge sets `err_flag` from that edge on. Only `rst_n` clears it.
- R9: While the asynchronous `rst_n` is low, both reset outputs are low, `err_flag` is 0, `pwr_inhibit` is 0 and `reg_en` is 1.
- R10: A fault that appears during the release delay restarts the delay. Release then comes on the 52nd fault-free tick after the last fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | One-cycle time-base strobe |
| sup_uv | input | 1 | Supply undervoltage comparator flag |
| sup_ov | input | 1 | Supply overvoltage comparator flag (raw) |
| reg_uv | input | 1 | Regulator output undervoltage flag |
| reg_ov | input | 1 | Regulator output overvoltage flag |
| rst_a_n | output | 1 | Reset output A, active low |
| rst_b_n | output | 1 | Reset output B, active low |
| reg_en | output | 1 | Regulator enable |
| pwr_inhibit | output | 1 | Forces relay and lamp drivers off |
| err_flag | output | 1 | Sticky regulator overvoltage error |

## Verification
A release counter that is off by one shows up as a reset edge one tick early or late. The bench samples exactly at the 51st and 52nd ticks, so this fault is caught within 52 ticks of any clean fault clearance. A filter counter that fails to saturate, or fails to step down, shows up as `pwr_inhibit` toggling on the wrong tick after a two-tick burst or a three-tick removal. A lost power-up latch shows up at the ports as reset dropping on a later `sup_uv` pulse. The random phase compares every output against a cycle model on every clock, so any divergent internal state is reported on the first cycle it reaches a port.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
   typedef struct packed {
      logic sup_uv;
      logic sup_ov;
      logic reg_uv;
      logic reg_ov;
   } volt_flags_t;
endpackage

// File: rtl/srs_persist_filter.sv
module srs_persist_filter #(
   parameter int CNT_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw,
   output logic filt
);
   if (CNT_W < 0 || CNT_W > 6) begin : g_bad_w
      $error("srs_persist_filter: CNT_W out of range");
   end

   if (CNT_W == 0) begin : g_bypass
      assign filt = raw;
   end else begin : g_counter
      localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
      logic [CNT_W-1:0] level_q, level_nx;
      logic             filt_q;

      always_comb begin
         level_nx = level_q;
         if (raw && level_q != TOP)
            level_nx = level_q + 1'b1;
         else if (!raw && level_q != '0)
            level_nx = level_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= '0;
            filt_q  <= 1'b0;
         end else if (tick) begin
            level_q <= level_nx;
            if (level_nx == TOP)
               filt_q <= 1'b1;
            else if (level_nx == '0)
               filt_q <= 1'b0;
         end
      end

      assign filt = filt_q;
   end
endmodule

// File: rtl/srs_release_timer.sv
module srs_release_timer #(
   parameter int DELAY_TICKS = 52
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fault,
   output logic hold_n,
   output logic up_done
);
   localparam int CW = $clog2(DELAY_TICKS);
   localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

   if (DELAY_TICKS < 2) begin : g_bad_delay
      $error("srs_release_timer: DELAY_TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          hold_q;
   logic          up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= 1'b1;
         up_q   <= 1'b0;
      end else if (fault) begin
         cnt_q  <= '0;
         hold_q <= 1'b1;
      end else if (tick && hold_q) begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
            up_q   <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign hold_n  = ~hold_q;
   assign up_done = up_q;
endmodule

// File: rtl/srs_err_latch.sv
module srs_err_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
   import sup_rst_pkg::*;
#(
   parameter int FILT_W      = 2,
   parameter int DELAY_TICKS = 52,
   parameter int NUM_RST     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sup_uv,
   input  logic sup_ov,
   input  logic reg_uv,
   input  logic reg_ov,
   output logic rst_a_n,
   output logic rst_b_n,
   output logic reg_en,
   output logic pwr_inhibit,
   output logic err_flag
);
   if (NUM_RST != 2) begin : g_bad_num
      $error("supply_reset_seq: exactly two reset outputs are provided");
   end

   volt_flags_t flags;
   logic        ov_acc;
   logic        up_done;
   logic        hold_n;
   logic        fault;
   logic [NUM_RST-1:0] rst_vec;

   assign flags = '{sup_uv: sup_uv, sup_ov: sup_ov, reg_uv: reg_uv, reg_ov: reg_ov};

   srs_persist_filter #(.CNT_W(FILT_W)) u_ov_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw(flags.sup_ov), .filt(ov_acc)
   );

   assign fault = (flags.sup_uv && !up_done) || ov_acc || flags.reg_uv || flags.reg_ov;

   srs_release_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fault(fault),
      .hold_n(hold_n), .up_done(up_done)
   );

   srs_err_latch u_err (
      .clk(clk), .rst_n(rst_n), .set(flags.reg_ov), .flag(err_flag)
   );

   for (genvar i = 0; i < NUM_RST; i++) begin : g_rst_fan
      assign rst_vec[i] = hold_n;
   end

   assign rst_a_n     = rst_vec[0];
   assign rst_b_n     = rst_vec[NUM_RST-1];
   assign pwr_inhibit = ov_acc;
   assign reg_en      = ~ov_acc;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic sup_ov,
   input logic reg_uv,
   input logic reg_ov,
   input logic rst_a_n,
   input logic rst_b_n,
   input logic pwr_inhibit,
   input logic err_flag
);
   // R1: regulator fault holds reset on the next edge
   a_r1_reg_fault_resets: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_uv || reg_ov) |=> !rst_a_n);

   // R2: both outputs agree
   a_r2_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
      rst_a_n == rst_b_n);

   // R3: acceptance only on a tick with raw overvoltage present
   a_r3_accept_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_inhibit) |-> ($past(tick) && $past(sup_ov)));

   // R4: withdrawal only on a tick with raw overvoltage absent
   a_r4_withdraw_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_inhibit) |-> ($past(tick) && !$past(sup_ov)));

   // R5: release happens only on a tick with no regulator fault
   a_r5_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_a_n) |-> ($past(tick) && !$past(reg_uv) && !$past(reg_ov)));

   // R7: accepted overvoltage holds reset
   a_r7_inhibit_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_inhibit |=> !rst_a_n);

   // R8: error flag is set by reg_ov and never clears
   a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ov |=> err_flag);
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
endmodule

bind supply_reset_seq supply_reset_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .sup_ov(sup_ov), .reg_uv(reg_uv),
   .reg_ov(reg_ov), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
   .pwr_inhibit(pwr_inhibit), .err_flag(err_flag)
);

// File: tb/supply_reset_seq_bench.sv
module supply_reset_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DLY = 52;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, sup_uv = 1'b0, sup_ov = 1'b0, reg_uv = 1'b0, reg_ov = 1'b0;
   logic rst_a_n, rst_b_n, reg_en, pwr_inhibit, err_flag;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   supply_reset_seq u_supply_reset_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sup_uv(sup_uv), .sup_ov(sup_ov),
      .reg_uv(reg_uv), .reg_ov(reg_ov), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
      .reg_en(reg_en), .pwr_inhibit(pwr_inhibit), .err_flag(err_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // cycle model built from the requirements
   int  m_fc;
   bit  m_ov, m_hold, m_up, m_err;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_fc = 0; m_ov = 0; m_hold = 1; m_up = 0; m_err = 0;
         m_cnt = 0;
      end else begin
         bit f;
         f = (sup_uv && !m_up) || m_ov || reg_uv || reg_ov;
         if (reg_ov) m_err = 1;
         if (f) begin m_hold = 1; m_cnt = 0; end
         else if (tick && m_hold) begin
            if (m_cnt == DLY-1) begin m_hold = 0; m_up = 1; m_cnt = 0; end
            else m_cnt++;
         end
         if (tick) begin
            if (sup_ov && m_fc < 3) m_fc++;
            else if (!sup_ov && m_fc > 0) m_fc--;
            if (m_fc == 3) m_ov = 1;
            else if (m_fc == 0) m_ov = 0;
         end
      end
   end
   int m_cnt;

   function automatic bit exp_reg_en(bit ov);
      return !ov;
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      sup_uv = 1'b1;
      repeat (3) step();
      chk(rst_a_n, 1'b0, "R9 reset out A");
      chk(rst_b_n, 1'b0, "R9 reset out B");
      chk(reg_en, 1'b1, "R9 reg_en");
      chk(pwr_inhibit, 1'b0, "R9 inhibit");
      chk(err_flag, 1'b0, "R9 err");
      rst_n = 1'b1;
      tick_n(60);
      chk(rst_a_n, 1'b0, "R1 supply UV holds during power-up");
      sup_uv = 1'b0;
      tick_n(DLY-1); step();
      chk(rst_a_n, 1'b0, "R5 still low at 51");
      tick_n(1); step();
      chk(rst_a_n, 1'b1, "R5 high at 52");
      chk(rst_b_n, 1'b1, "R2 output B follows");
      sup_uv = 1'b1; tick_n(5); step();
      chk(rst_a_n, 1'b1, "R6 supply UV ignored after power-up");
      sup_uv = 1'b0;
      // two-tick burst ignored
      sup_ov = 1'b1; tick_n(2); sup_ov = 1'b0; tick_n(2); step();
      chk(pwr_inhibit, 1'b0, "R3 short burst ignored");
      chk(rst_a_n, 1'b1, "R3 reset unaffected by burst");
      sup_ov = 1'b1; tick_n(3); step();
      chk(pwr_inhibit, 1'b1, "R3 accepted at third tick");
      chk(reg_en, exp_reg_en(1'b1), "R7 regulator off");
      chk(rst_a_n, 1'b0, "R1 accepted OV resets");
      chk(rst_b_n, 1'b0, "R2 output B low");
      sup_ov = 1'b0; tick_n(2); step();
      chk(pwr_inhibit, 1'b1, "R4 held after two low ticks");
      tick_n(1); step();
      chk(pwr_inhibit, 1'b0, "R4 withdrawn at third low tick");
      chk(reg_en, 1'b1, "R7 regulator back on");
      tick_n(30);
      @(negedge clk) reg_uv = 1'b1;
      @(negedge clk) reg_uv = 1'b0;
      tick_n(DLY-1); step();
      chk(rst_a_n, 1'b0, "R10 delay restarted");
      tick_n(1); step();
      chk(rst_a_n, 1'b1, "R10 release after restart");
      @(negedge clk) reg_uv = 1'b1;
      step();
      chk(rst_a_n, 1'b0, "R1 reg_uv resets");
      reg_uv = 1'b0;
      @(negedge clk) reg_ov = 1'b1;
      @(negedge clk) reg_ov = 1'b0;
      chk(err_flag, 1'b1, "R8 err set");
      chk(rst_a_n, 1'b0, "R1 reg_ov resets");
      tick_n(DLY); step();
      chk(err_flag, 1'b1, "R8 err sticky");
      chk(rst_a_n, 1'b1, "R5 release after reg_ov");
      // random phase against the model
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         chk(rst_a_n, !m_hold, "R1 R5 R10 random reset");
         chk(rst_b_n, !m_hold, "R2 random reset B");
         chk(pwr_inhibit, m_ov, "R3 R4 random inhibit");
         chk(reg_en, exp_reg_en(m_ov), "R7 random reg_en");
         chk(err_flag, m_err, "R8 random err");
         tick   = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 5) == 0) sup_ov = ~sup_ov;
         sup_uv = ($urandom_range(0, 7) == 0);
         reg_uv = ($urandom_range(0, 299) == 0);
         reg_ov = ($urandom_range(0, 1999) == 0);
      end
      @(negedge clk) rst_n = 1'b0;
      #1;
      chk(err_flag, 1'b0, "R8 err cleared by power-on reset");
      chk(rst_a_n, 1'b0, "R9 async reset asserts");
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule